// File: doc/BRIEF.md
# Policy-Configurable Countdown Timer

This block is a down-counter driven by a tick strobe from elsewhere in the chip. Each tick moves the count one step toward zero. When the count runs out, the block raises a one-cycle trigger. In periodic mode it then reloads from a limit register. In one-shot mode it parks at zero and turns itself off.

A small policy mask changes the corner behaviour. Its bits cover what happens when a count of zero is armed, whether a reload happens at once or one tick later, whether a period lasts one extra tick, and whether a zero limit keeps firing on every tick. Software drives the block through single-cycle strobes: write count, write limit (with an optional copy into the count), start (periodic or one-shot) and stop. It reads the live count from `count_o`.

The policy mask is meant to stay static. One pairing of bits is contradictory, and the block flags it and refuses to start while it is present.

Top module: `timer_policy_ctr`

## Requirements
- R1: After reset, `count_o` is 0, the internal limit is 0, `mode_o` is 0 and `trig_o` is 0. `mode_o` encodes off as 0, periodic as 1 and one-shot as 2.
- R2: While running and no command is taken, each tick with a count above 1 lowers the count by one. A cycle without a tick leaves the count, mode and trigger unchanged. A cycle that takes a command ignores its tick.
- R3: In periodic mode without the wrap policy, a tick at count 1 pulses `trig_o` in the following cycle and loads the count with the limit.
- R4: In one-shot mode, a tick at count 1 pulses `trig_o`, sets the count to 0 and the mode to 0.
- R5: Arming means three things: a start from off, a count write while running, or a limit write with reload while running. Arming with a zero value pulses `trig_o` at once, unless policy bit 2 (late trigger) or policy bit 4 (decrement-only trigger) is set.
- R6: When arming, a zero value is replaced by the limit unless policy bit 3 (late reload) is set. With bit 3 set, in periodic mode with a non-zero limit, the count stays 0 and the next tick loads the limit without a trigger. If arming ends at zero and no policy keeps the timer running, the mode becomes 0.
- R7: With policy bit 0 (wrap), a periodic expiry at count 1 triggers and leaves the count at 0. The next tick loads the limit without a trigger, so a period lasts limit+1 ticks.
- R8: With policy bit 1 (continuous), a periodic timer with a zero limit triggers on every tick. Without bit 1, a periodic expiry with a zero limit triggers and turns the timer off.
- R9: With policy bit 2 set, a running timer at count 0 triggers on the next tick. A periodic timer then reloads; a one-shot timer turns off.
- R10: `err_o` is high exactly while policy bits 2 and 4 are both set. While it is high, start requests are ignored.
- R11: Stop sets the mode to 0 and keeps the count. A count write while off only loads the count. A start while running changes only the mode.
- R12: A limit write always updates the limit, which then applies in that same cycle. With the reload flag, the value is also copied into the count.
- R13: When several commands arrive in one cycle, only the highest-ranked one acts. The ranking is stop, then count write, then start, then the limit reload copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count-step strobe |
| policy_i | input | 5 | Policy mask (bit0 wrap, bit1 continuous, bit2 late trigger, bit3 late reload, bit4 decrement-only trigger) |
| stop_i | input | 1 | Stop request |
| cnt_wr_i | input | 1 | Count write strobe |
| cnt_wdata_i | input | CNT_W | Count write value |
| start_i | input | 1 | Start request |
| start_oneshot_i | input | 1 | Start selects one-shot when high, periodic when low |
| lim_wr_i | input | 1 | Limit write strobe |
| lim_wdata_i | input | CNT_W | Limit write value |
| lim_reload_i | input | 1 | Limit write also copies into the count |
| count_o | output | CNT_W | Live count |
| mode_o | output | 2 | Current mode |
| trig_o | output | 1 | One-cycle trigger pulse |
| err_o | output | 1 | Illegal policy combination |

## Verification
The collisions of interest are a tick landing in the same cycle as a command, and two or more commands landing together (stop, count write, start, limit reload). The bench drives all strobes independently and often, with small count and limit values. This makes zero counts, zero limits and overlapping requests common under every one of the 32 policy masks. A behavioural model applies the ranking and the tick-ignore rule. Count, mode, trigger and error flag are compared with the model after every clock.

// File: rtl/timer_pkg.sv
package timer_pkg;

  localparam int POL_W         = 5;
  localparam int POL_WRAP      = 0;
  localparam int POL_CONT      = 1;
  localparam int POL_NOITRIG   = 2;
  localparam int POL_NOIRELOAD = 3;
  localparam int POL_DECONLY   = 4;

  typedef enum logic [1:0] {
    MODE_OFF = 2'd0,
    MODE_PER = 2'd1,
    MODE_ONE = 2'd2
  } tmr_mode_e;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_STOP,
    CMD_CNT,
    CMD_START,
    CMD_RELOAD
  } tmr_cmd_e;

  // Field order mirrors the bit positions of the raw mask (msb first).
  typedef struct packed {
    logic deconly;
    logic noireload;
    logic noitrig;
    logic cont;
    logic wrap;
  } tmr_pol_t;

  function automatic logic pol_conflict(tmr_pol_t p);
    return p.noitrig & p.deconly;
  endfunction

endpackage

// File: rtl/timer_pol_check.sv
module timer_pol_check
  import timer_pkg::*;
(
  input  logic [POL_W-1:0] pol_raw_i,
  output tmr_pol_t         pol_o,
  output logic             err_o
);

  assign pol_o = tmr_pol_t'(pol_raw_i);
  assign err_o = pol_conflict(pol_o);

  always_comb begin
    a_r10_err_flag : assert (err_o == (pol_raw_i[POL_NOITRIG] & pol_raw_i[POL_DECONLY]));
  end

endmodule

// File: rtl/timer_cmd_arb.sv
module timer_cmd_arb
  import timer_pkg::*;
(
  input  logic     stop_i,
  input  logic     cnt_wr_i,
  input  logic     start_i,
  input  logic     start_block_i,
  input  logic     lim_wr_i,
  input  logic     lim_reload_i,
  output tmr_cmd_e cmd_o
);

  logic start_ok;
  assign start_ok = start_i & ~start_block_i;

  always_comb begin
    if (stop_i)                      cmd_o = CMD_STOP;
    else if (cnt_wr_i)               cmd_o = CMD_CNT;
    else if (start_ok)               cmd_o = CMD_START;
    else if (lim_wr_i && lim_reload_i) cmd_o = CMD_RELOAD;
    else                             cmd_o = CMD_NONE;
  end

endmodule

// File: rtl/timer_core.sv
module timer_core
  import timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  tmr_cmd_e         cmd_i,
  input  tmr_pol_t         pol_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic             start_oneshot_i,
  input  logic             lim_wr_i,
  input  logic [CNT_W-1:0] lim_wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output tmr_mode_e        mode_o,
  output logic             trig_o
);

  localparam logic [CNT_W-1:0] CNT_ZERO = '0;
  localparam logic [CNT_W-1:0] CNT_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  typedef struct packed {
    tmr_mode_e        mode;
    logic [CNT_W-1:0] cnt;
    logic             hold;
    logic             trig;
  } nxt_t;

  logic [CNT_W-1:0] cnt_q, lim_q, lim_eff;
  tmr_mode_e        mode_q;
  logic             hold_q, trig_q;
  nxt_t             nx;

  // Load a value into a running timer.
  function automatic nxt_t arm_fn(logic [CNT_W-1:0] d, logic [CNT_W-1:0] lim,
                                  tmr_mode_e md, tmr_pol_t p);
    nxt_t r;
    logic zero, keep;
    zero   = (d == CNT_ZERO);
    r.mode = md;
    r.hold = 1'b0;
    r.trig = zero & ~p.noitrig & ~p.deconly;
    r.cnt  = (zero && !p.noireload) ? lim : d;
    keep   = (r.cnt != CNT_ZERO)
           | (p.cont & (md == MODE_PER) & (lim == CNT_ZERO))
           | p.noitrig
           | (p.noireload & (md == MODE_PER) & (lim != CNT_ZERO));
    if (!keep) r.mode = MODE_OFF;
    return r;
  endfunction

  // One tick of a running timer.
  function automatic nxt_t step_fn(logic [CNT_W-1:0] c, logic h, logic [CNT_W-1:0] lim,
                                   tmr_mode_e md, tmr_pol_t p);
    nxt_t r;
    r.mode = md;
    r.cnt  = c;
    r.hold = h;
    r.trig = 1'b0;
    if (c > CNT_ONE) begin
      r.cnt = c - CNT_ONE;
    end else if (c == CNT_ONE) begin
      r.trig = 1'b1;
      if (md == MODE_ONE) begin
        r.cnt  = CNT_ZERO;
        r.mode = MODE_OFF;
      end else if (p.wrap && lim != CNT_ZERO) begin
        r.cnt  = CNT_ZERO;
        r.hold = 1'b1;
      end else begin
        r.cnt = lim;
        if (lim == CNT_ZERO && !p.cont) r.mode = MODE_OFF;
      end
    end else begin
      r.trig = ~h & (p.noitrig | (p.cont & (lim == CNT_ZERO)));
      if (md == MODE_ONE) begin
        r.mode = MODE_OFF;
      end else begin
        r.cnt  = lim;
        r.hold = 1'b0;
        if (lim == CNT_ZERO && !p.cont) r.mode = MODE_OFF;
      end
    end
    return r;
  endfunction

  // Named events for the checks below.
  logic      ev_tick_run, ev_expire;
  tmr_mode_e start_mode;

  assign lim_eff     = lim_wr_i ? lim_wdata_i : lim_q;
  assign start_mode  = start_oneshot_i ? MODE_ONE : MODE_PER;
  assign ev_tick_run = (cmd_i == CMD_NONE) && tick_i && (mode_q != MODE_OFF);
  assign ev_expire   = ev_tick_run && (cnt_q == CNT_ONE);

  always_comb begin
    nx.mode = mode_q;
    nx.cnt  = cnt_q;
    nx.hold = hold_q;
    nx.trig = 1'b0;
    case (cmd_i)
      CMD_STOP: begin
        nx.mode = MODE_OFF;
        nx.hold = 1'b0;
      end
      CMD_CNT: begin
        if (mode_q == MODE_OFF) nx.cnt = cnt_wdata_i;
        else nx = arm_fn(cnt_wdata_i, lim_eff, mode_q, pol_i);
      end
      CMD_START: begin
        if (mode_q == MODE_OFF) nx = arm_fn(cnt_q, lim_eff, start_mode, pol_i);
        else nx.mode = start_mode;
      end
      CMD_RELOAD: begin
        if (mode_q == MODE_OFF) nx.cnt = lim_wdata_i;
        else nx = arm_fn(lim_wdata_i, lim_eff, mode_q, pol_i);
      end
      default: begin
        if (ev_tick_run) nx = step_fn(cnt_q, hold_q, lim_eff, mode_q, pol_i);
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= CNT_ZERO;
      lim_q  <= CNT_ZERO;
      mode_q <= MODE_OFF;
      hold_q <= 1'b0;
      trig_q <= 1'b0;
    end else begin
      cnt_q  <= nx.cnt;
      lim_q  <= lim_eff;
      mode_q <= nx.mode;
      hold_q <= nx.hold;
      trig_q <= nx.trig;
    end
  end

  assign cnt_o  = cnt_q;
  assign mode_o = mode_q;
  assign trig_o = trig_q;

  a_r2_decrement : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_tick_run && cnt_q > CNT_ONE) |=> (cnt_q == $past(cnt_q) - CNT_ONE) && !trig_q);

  a_r2_no_tick_hold : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_NONE && !tick_i) |=> $stable(cnt_q) && $stable(mode_q) && !trig_q);

  a_r3_periodic_reload : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_expire && mode_q == MODE_PER && !pol_i.wrap) |=> trig_q && (cnt_q == $past(lim_eff)));

  a_r4_oneshot_end : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_expire && mode_q == MODE_ONE) |=> trig_q && (cnt_q == CNT_ZERO) && (mode_q == MODE_OFF));

  a_r7_wrap_zero : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_expire && mode_q == MODE_PER && pol_i.wrap && lim_eff != CNT_ZERO)
      |=> trig_q && (cnt_q == CNT_ZERO) && (mode_q == MODE_PER));

  a_r11_stop_keeps_count : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_STOP) |=> (mode_q == MODE_OFF) && $stable(cnt_q) && !trig_q);

endmodule

// File: rtl/timer_policy_ctr.sv
module timer_policy_ctr
  import timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [4:0]       policy_i,
  input  logic             stop_i,
  input  logic             cnt_wr_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic             start_i,
  input  logic             start_oneshot_i,
  input  logic             lim_wr_i,
  input  logic [CNT_W-1:0] lim_wdata_i,
  input  logic             lim_reload_i,
  output logic [CNT_W-1:0] count_o,
  output logic [1:0]       mode_o,
  output logic             trig_o,
  output logic             err_o
);

  tmr_pol_t  pol;
  tmr_cmd_e  cmd;
  tmr_mode_e mode;

  timer_pol_check u_pol (
    .pol_raw_i (policy_i),
    .pol_o     (pol),
    .err_o     (err_o)
  );

  timer_cmd_arb u_arb (
    .stop_i        (stop_i),
    .cnt_wr_i      (cnt_wr_i),
    .start_i       (start_i),
    .start_block_i (err_o),
    .lim_wr_i      (lim_wr_i),
    .lim_reload_i  (lim_reload_i),
    .cmd_o         (cmd)
  );

  timer_core #(.CNT_W(CNT_W)) u_core (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .tick_i          (tick_i),
    .cmd_i           (cmd),
    .pol_i           (pol),
    .cnt_wdata_i     (cnt_wdata_i),
    .start_oneshot_i (start_oneshot_i),
    .lim_wr_i        (lim_wr_i),
    .lim_wdata_i     (lim_wdata_i),
    .cnt_o           (count_o),
    .mode_o          (mode),
    .trig_o          (trig_o)
  );

  assign mode_o = mode;

  a_r10_start_refused : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && mode_o == 2'd0) |=> (mode_o == 2'd0));

  a_r13_stop_wins : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && (cnt_wr_i || start_i)) |=> (mode_o == 2'd0) && $stable(count_o));

endmodule

// File: tb/timer_policy_ctr_tb_top.sv
module timer_policy_ctr_tb_top;

  localparam int CNT_W    = 16;
  localparam int CYC_POL  = 400;
  localparam int WATCHDOG = 200000;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             tick = 1'b0, stop = 1'b0, cnt_wr = 1'b0, start = 1'b0, start_one = 1'b0;
  logic             lim_wr = 1'b0, lim_rel = 1'b0;
  logic [4:0]       policy = '0;
  logic [CNT_W-1:0] cnt_wd = '0, lim_wd = '0;
  logic [CNT_W-1:0] count_o;
  logic [1:0]       mode_o;
  logic             trig_o, err_o;

  always #4 clk = ~clk;

  timer_policy_ctr #(.CNT_W(CNT_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .policy_i(policy),
    .stop_i(stop), .cnt_wr_i(cnt_wr), .cnt_wdata_i(cnt_wd),
    .start_i(start), .start_oneshot_i(start_one),
    .lim_wr_i(lim_wr), .lim_wdata_i(lim_wd), .lim_reload_i(lim_rel),
    .count_o(count_o), .mode_o(mode_o), .trig_o(trig_o), .err_o(err_o)
  );

  // Reference model state: value expected after the coming edge.
  int    m_mode, m_cnt, m_lim, m_hold, m_trig;
  int    p_wrap, p_cont, p_nit, p_nir, p_dec;
  string tag;
  int    n_vec = 0, n_bad = 0;
  bit    done = 1'b0;

  task automatic check(string what, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d (policy %b, t=%0t)", tag, what, act, exp, policy, $time);
    end
  endtask

  task automatic m_reset();
    m_mode = 0; m_cnt = 0; m_lim = 0; m_hold = 0; m_trig = 0;
    tag = "R1";
  endtask

  task automatic m_arm(int d, int le);
    bit z, stay;
    z = (d == 0);
    m_trig = (z && !p_nit && !p_dec) ? 1 : 0;
    if (z && !p_nir) d = le;
    m_hold = 0;
    stay = 1'b0;
    if (d != 0) stay = 1'b1;
    else if (p_cont && m_mode == 1 && le == 0) stay = 1'b1;
    else if (p_nit) stay = 1'b1;
    else if (p_nir && m_mode == 1 && le != 0) stay = 1'b1;
    if (!stay) m_mode = 0;
    m_cnt = d;
    tag = z ? "R5/R6" : "R5";
  endtask

  task automatic m_tick(int le);
    if (m_cnt >= 2) begin
      m_cnt = m_cnt - 1; tag = "R2";
    end else if (m_cnt == 1) begin
      m_trig = 1;
      if (m_mode == 2) begin
        m_cnt = 0; m_mode = 0; tag = "R4";
      end else if (p_wrap && le != 0) begin
        m_cnt = 0; m_hold = 1; tag = "R7";
      end else begin
        m_cnt = le;
        if (le == 0 && !p_cont) m_mode = 0;
        tag = (le == 0) ? "R8" : "R3";
      end
    end else begin
      m_trig = (!m_hold && (p_nit || (p_cont && le == 0))) ? 1 : 0;
      tag = p_nit ? "R9" : (m_hold ? "R7" : (le == 0 ? "R8" : "R6"));
      if (m_mode == 2) m_mode = 0;
      else begin
        m_cnt = le; m_hold = 0;
        if (le == 0 && !p_cont) m_mode = 0;
      end
    end
  endtask

  task automatic m_apply();
    int  le;
    bit  err;
    le     = lim_wr ? int'(lim_wd) : m_lim;
    err    = p_nit && p_dec;
    m_trig = 0;
    tag    = "R2";
    if (stop) begin
      m_mode = 0; m_hold = 0; tag = (cnt_wr || start) ? "R13" : "R11";
    end else if (cnt_wr) begin
      if (m_mode == 0) begin m_cnt = int'(cnt_wd); tag = "R11"; end
      else m_arm(int'(cnt_wd), le);
    end else if (start && !err) begin
      if (m_mode == 0) begin
        m_mode = start_one ? 2 : 1;
        m_arm(m_cnt, le);
      end else begin
        m_mode = start_one ? 2 : 1; tag = "R11";
      end
    end else if (lim_wr && lim_rel) begin
      if (m_mode == 0) begin m_cnt = int'(lim_wd); tag = "R12"; end
      else m_arm(int'(lim_wd), le);
    end else if (tick && m_mode != 0) begin
      m_tick(le);
    end else if (start && err) begin
      tag = "R10";
    end
    m_lim = le;
  endtask

  task automatic compare();
    check("count", int'(count_o), m_cnt);
    check("mode", int'(mode_o), m_mode);
    check("trig", int'(trig_o), m_trig);
    begin
      string keep;
      keep = tag; tag = "R10";
      check("err", int'(err_o), (p_nit && p_dec) ? 1 : 0);
      tag = keep;
    end
  endtask

  task automatic pick_inputs();
    tick      = ($urandom_range(0, 99) < 55);
    stop      = ($urandom_range(0, 99) < 4);
    cnt_wr    = ($urandom_range(0, 99) < 6);
    cnt_wd    = CNT_W'($urandom_range(0, 6));
    start     = ($urandom_range(0, 99) < ((m_mode == 0) ? 25 : 4));
    start_one = ($urandom_range(0, 99) < 40);
    lim_wr    = ($urandom_range(0, 99) < 5);
    lim_wd    = CNT_W'($urandom_range(0, 5));
    lim_rel   = ($urandom_range(0, 1) == 1);
  endtask

  task automatic quiet_inputs();
    tick = 1'b0; stop = 1'b0; cnt_wr = 1'b0; start = 1'b0; start_one = 1'b0;
    lim_wr = 1'b0; lim_rel = 1'b0; cnt_wd = '0; lim_wd = '0;
  endtask

  initial begin
    quiet_inputs();
    for (int p = 0; p < 32; p++) begin
      @(negedge clk);
      rst_n  = 1'b0;
      policy = 5'(p);
      p_wrap = p & 1; p_cont = (p >> 1) & 1; p_nit = (p >> 2) & 1;
      p_nir  = (p >> 3) & 1; p_dec = (p >> 4) & 1;
      quiet_inputs();
      m_reset();
      @(negedge clk);
      compare();             // R1 reset state, R10 flag under this mask
      rst_n = 1'b1;
      for (int c = 0; c < CYC_POL; c++) begin
        pick_inputs();
        m_apply();
        @(negedge clk);
        compare();
      end
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule